// File: doc/BRIEF.md
# I2C Register-Write Target

This block is an I2C target that gives an external bus controller access to a small on-chip register file. SCL and SDA are brought into the system clock domain through a short synchronizer and edge-detected there. A 7-bit address is compared against a fixed six-bit prefix followed by one bit taken from a strap pin. A matching write carries a subaddress byte and then any number of data bytes. Each data byte is acknowledged and leaves the block as a one-cycle write strobe with address and data. A matching read returns the content of the selected register.

The subaddress is held fixed for the whole transfer, so a burst of data bytes always hits the same register, and a burst of reads returns the same register again and again. Open-drain pads sit outside the block: each line has an output enable that, when high, pulls the line low. The host logic can stall the bus with a wait state through `busy` and can refuse data through `accept`.

Top module: `i2c_regwr_target`

## Requirements
- R1: A start (SDA falling while SCL is high) moves the target to address reception from any state, including the middle of a byte. A stop (SDA rising while SCL is high) returns it to idle. Neither a byte cut short this way nor the transfer it belonged to causes a write strobe.
- R2: The target acknowledges an address byte whose upper seven bits, MSB first, equal 1,0,1,1,1,0,X, where X is the level of `addr_strap`. It does so by pulling SDA low for the entire high period of the ninth clock. The eighth bit selects the direction: 0 is a write and 1 is a read.
- R3: On an address mismatch the target leaves SDA released during the acknowledge clock. It then ignores the bus (no acknowledge, no strobe) until the next start or stop.
- R4: In a write, the byte after the address is the subaddress and each later byte is data. Every one is acknowledged. After the ninth clock of each acknowledged data byte, `wr_stb` pulses for exactly one cycle with `wr_addr` equal to the subaddress and `wr_data` equal to the byte.
- R5: The subaddress does not advance. All data bytes of one write, and all bytes of one read, use the subaddress last written.
- R6: In a read, the target drives the register selected by the stored subaddress MSB first, changing SDA only while SCL is low. It sends the next byte (the same register again) whenever the controller acknowledges.
- R7: When the controller does not acknowledge a read byte, the target releases SDA and sends nothing more until the next start or stop.
- R8: While `busy` is high when an acknowledge bit begins, the target holds SCL low and releases it only once `busy` is low.
- R9: When `accept` is low during a data byte's acknowledge, the target leaves SDA released, issues no strobe and ignores further bytes until a start or stop.
- R10: After reset both output enables and `wr_stb` are low. SDA driven by the target does not change while SCL stays high.
- R11: The register file resets to zero. Only the low four bits of the subaddress select one of its 16 registers, and a strobed write is visible to a later read of any subaddress with the same low bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr_strap | input | 1 | Level that sets the lowest address bit |
| busy | input | 1 | Host not ready; stretches SCL at the acknowledge bit |
| accept | input | 1 | Host can take a data byte; low forces a not-acknowledge |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| scl_oe | output | 1 | Pull SCL low when high |
| sda_oe | output | 1 | Pull SDA low when high |
| wr_stb | output | 1 | One-cycle register write strobe |
| wr_addr | output | 8 | Subaddress of the write |
| wr_data | output | 8 | Data byte of the write |

## Verification
The embedded assertions watch, on every clock, that the write strobe is a single-cycle pulse issued only from a data acknowledge, and that target-driven SDA stays still while SCL is high. They also watch that SCL is only held while it is already low, and that a mismatched address never gets an acknowledge. Whole-transfer behaviour can only be shown by the bench scenarios: address matching against the strap, the fixed subaddress over multi-byte bursts, read-back content and aliasing, the not-acknowledge paths, wait-state length, and recovery from a start or stop in the middle of a byte.

// File: rtl/i2c_tgt_pkg.sv
`timescale 1ns/1ps
package i2c_tgt_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_SUB,
    ST_SUB_ACK,
    ST_WDAT,
    ST_WDAT_ACK,
    ST_RDAT,
    ST_RDAT_ACK,
    ST_PARK
  } tgt_state_e;
endpackage

// File: rtl/i2c_tgt_sync.sv
`timescale 1ns/1ps
module i2c_tgt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES:0] scl_pipe;
  logic [STAGES:0] sda_pipe;
  logic            scl_q;
  logic            sda_q;

  // bus idles high, so the pipes reset to ones
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-1:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-1:0], sda_i};
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign scl_q     = scl_pipe[STAGES];
  assign sda_s     = sda_pipe[STAGES-1];
  assign sda_q     = sda_pipe[STAGES];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_tgt_regfile.sv
`timescale 1ns/1ps
module i2c_tgt_regfile #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/i2c_tgt_fsm.sv
`timescale 1ns/1ps
module i2c_tgt_fsm
  import i2c_tgt_pkg::*;
#(
  parameter logic [5:0] ADDR_HI = 6'b101110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              strap,
  input  logic              busy,
  input  logic              accept,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              wr_stb,
  output logic [BYTE_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data
);
  localparam int CW = $clog2(BYTE_W + 1);

  tgt_state_e        state_q, state_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [BYTE_W-1:0] sr_q, sr_d;
  logic [BYTE_W-1:0] tx_q, tx_d;
  logic [BYTE_W-1:0] sub_q, sub_d;
  logic [BYTE_W-1:0] wdat_q, wdat_d;
  logic              launch_q, launch_d;
  logic              ack_q, ack_d;
  logic              mack_q, mack_d;
  logic              stb_q, stb_d;
  logic              in_ack;
  logic              addr_match;
  logic              ack_ok;

  assign in_ack     = (state_q == ST_ADDR_ACK) || (state_q == ST_SUB_ACK) ||
                      (state_q == ST_WDAT_ACK);
  assign addr_match = (sr_q[BYTE_W-1:1] == {ADDR_HI, strap});

  always_comb begin
    unique case (state_q)
      ST_ADDR_ACK: ack_ok = addr_match;
      ST_WDAT_ACK: ack_ok = accept;
      default:     ack_ok = 1'b1;
    endcase
  end

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    sr_d     = sr_q;
    tx_d     = tx_q;
    sub_d    = sub_q;
    wdat_d   = wdat_q;
    launch_d = launch_q;
    ack_d    = ack_q;
    mack_d   = mack_q;
    stb_d    = 1'b0;
    if (stop_det) begin
      state_d = ST_IDLE;
      ack_d   = 1'b0;
      cnt_d   = '0;
    end else if (start_det) begin
      state_d = ST_ADDR;
      ack_d   = 1'b0;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_SUB, ST_WDAT: begin
          if (scl_rise) begin
            sr_d  = {sr_q[BYTE_W-2:0], sda_s};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && (cnt_q == CW'(BYTE_W))) begin
            cnt_d    = '0;
            launch_d = 1'b0;
            if (state_q == ST_ADDR)     state_d = ST_ADDR_ACK;
            else if (state_q == ST_SUB) state_d = ST_SUB_ACK;
            else                        state_d = ST_WDAT_ACK;
          end
        end
        ST_ADDR_ACK, ST_SUB_ACK, ST_WDAT_ACK: begin
          if (!launch_q) begin
            if (!busy) begin
              launch_d = 1'b1;
              ack_d    = ack_ok;
            end
          end else if (scl_fall) begin
            ack_d = 1'b0;
            if (state_q == ST_ADDR_ACK) begin
              if (!ack_q) begin
                state_d = ST_PARK;
              end else if (sr_q[0]) begin
                state_d = ST_RDAT;
                tx_d    = rd_data;
                cnt_d   = '0;
              end else begin
                state_d = ST_SUB;
              end
            end else if (state_q == ST_SUB_ACK) begin
              sub_d   = sr_q;
              state_d = ST_WDAT;
            end else if (ack_q) begin
              stb_d   = 1'b1;
              wdat_d  = sr_q;
              state_d = ST_WDAT;
            end else begin
              state_d = ST_PARK;
            end
          end
        end
        ST_RDAT: begin
          if (scl_fall) begin
            if (cnt_q == CW'(BYTE_W - 1)) begin
              state_d = ST_RDAT_ACK;
              cnt_d   = '0;
            end else begin
              tx_d  = {tx_q[BYTE_W-2:0], 1'b0};
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        ST_RDAT_ACK: begin
          if (scl_rise) begin
            mack_d = ~sda_s;
          end else if (scl_fall) begin
            if (mack_q) begin
              state_d = ST_RDAT;
              tx_d    = rd_data;
            end else begin
              state_d = ST_PARK;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      sr_q     <= '0;
      tx_q     <= '0;
      sub_q    <= '0;
      wdat_q   <= '0;
      launch_q <= 1'b0;
      ack_q    <= 1'b0;
      mack_q   <= 1'b0;
      stb_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      sr_q     <= sr_d;
      tx_q     <= tx_d;
      sub_q    <= sub_d;
      wdat_q   <= wdat_d;
      launch_q <= launch_d;
      ack_q    <= ack_d;
      mack_q   <= mack_d;
      stb_q    <= stb_d;
    end
  end

  // SCL is held from the start of each acknowledge bit until its decision is launched
  assign scl_oe  = in_ack && !launch_q;
  assign sda_oe  = (state_q == ST_RDAT) ? ~tx_q[BYTE_W-1] : ack_q;
  assign wr_stb  = stb_q;
  assign wr_addr = sub_q;
  assign wr_data = wdat_q;

  p_stb_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  p_stb_from_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> ($past(state_q) == ST_WDAT_ACK));

  p_sda_still_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s)) |-> $stable(sda_oe));

  p_hold_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    scl_oe |-> !scl_s);

  p_no_ack_mismatch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ADDR_ACK && launch_q && !addr_match) |-> !sda_oe);
endmodule

// File: rtl/i2c_regwr_target.sv
`timescale 1ns/1ps
module i2c_regwr_target
  import i2c_tgt_pkg::*;
#(
  parameter int         RAW         = 4,
  parameter int         SYNC_STAGES = 2,
  parameter logic [5:0] ADDR_HI     = 6'b101110
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       addr_strap,
  input  logic       busy,
  input  logic       accept,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic       wr_stb,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data
);
  logic [1:0]        rst_pipe;
  logic              rst_n_int;
  logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [BYTE_W-1:0] rd_data;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_int = rst_pipe[1];

  i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_tgt_fsm #(.ADDR_HI(ADDR_HI)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .strap     (addr_strap),
    .busy      (busy),
    .accept    (accept),
    .rd_data   (rd_data),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe),
    .wr_stb    (wr_stb),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data)
  );

  i2c_tgt_regfile #(.AW(RAW), .DW(BYTE_W)) u_regs (
    .clk   (clk),
    .rst_n (rst_n_int),
    .we    (wr_stb),
    .waddr (wr_addr[RAW-1:0]),
    .wdata (wr_data),
    .raddr (wr_addr[RAW-1:0]),
    .rdata (rd_data)
  );
endmodule

// File: tb/tb_i2c_regwr_target.sv
`timescale 1ns/1ps
module tb_i2c_regwr_target;
  localparam int H = 20;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       addr_strap, busy, accept;
  logic       m_scl, m_sda;
  logic       scl_line, sda_line;
  logic       scl_oe, sda_oe, wr_stb;
  logic [7:0] wr_addr, wr_data;

  int         n_chk = 0;
  int         n_fail = 0;
  int         glitch = 0;
  int         last_wait = 0;
  logic [15:0] exp_q[$];
  logic [7:0]  model [16];

  always #2.5 clk = ~clk;

  assign scl_line = !(m_scl || scl_oe);
  assign sda_line = !(m_sda || sda_oe);

  i2c_regwr_target dut (
    .clk(clk), .rst_n(rst_n), .addr_strap(addr_strap), .busy(busy),
    .accept(accept), .scl_i(scl_line), .sda_i(sda_line), .scl_oe(scl_oe),
    .sda_oe(sda_oe), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference: every strobe must match the head of the expected queue
  always @(negedge clk) begin
    if (rst_n && wr_stb) begin
      if (exp_q.size() == 0) begin
        chk("R4 unexpected strobe addr/data", {16'h0, wr_addr, wr_data}, 32'hFFFF_FFFF);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        chk("R4 R5 strobe addr/data", {wr_addr, wr_data}, e);
        model[e[11:8]] = e[7:0];
      end
    end
  end

  task automatic hw(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_high();
    int c = 0;
    while (!scl_line) begin
      @(negedge clk);
      c++;
    end
    last_wait = c;
  endtask

  task automatic m_start();
    m_sda = 1'b1; hw(H); m_scl = 1'b1; hw(H);
  endtask

  task automatic m_rstart();
    m_sda = 1'b0; hw(H); m_scl = 1'b0; wait_high(); hw(H);
    m_sda = 1'b1; hw(H); m_scl = 1'b1; hw(H);
  endtask

  task automatic m_stop();
    m_sda = 1'b1; hw(H); m_scl = 1'b0; wait_high(); hw(H);
    m_sda = 1'b0; hw(H);
  endtask

  task automatic wbit(input logic b);
    m_sda = !b; hw(H); m_scl = 1'b0; wait_high(); hw(H); m_scl = 1'b1;
  endtask

  task automatic rbit(output logic b);
    logic s0;
    m_sda = 1'b0; hw(H); m_scl = 1'b0; wait_high();
    s0 = sda_line; hw(H); b = sda_line;
    if (s0 !== b) glitch++;
    m_scl = 1'b1;
  endtask

  task automatic wbyte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) wbit(v[i]);
    rbit(b);
    ack = !b;
  endtask

  task automatic rbyte(output logic [7:0] v, input logic mack);
    for (int i = 7; i >= 0; i--) rbit(v[i]);
    wbit(!mack);
  endtask

  task automatic write_txn(input logic [7:0] ab, input logic [7:0] sub,
                           input logic [7:0] first, input int n, input logic match);
    logic a;
    m_start();
    wbyte(ab, a);
    chk(match ? "R2 address ack" : "R3 address not acked", a, match);
    wbyte(sub, a);
    chk(match ? "R4 subaddress ack" : "R3 bytes ignored", a, match);
    for (int k = 0; k < n; k++) begin
      logic [7:0] d;
      d = first + 8'(k * 17);
      if (match) exp_q.push_back({sub, d});
      wbyte(d, a);
      chk(match ? "R4 data ack" : "R3 data ignored", a, match);
    end
    m_stop();
    hw(4 * H);
  endtask

  task automatic read_txn(input logic [7:0] ab, input logic [7:0] sub, input int n);
    logic a, b;
    logic [7:0] v;
    m_start();
    wbyte(ab, a);
    wbyte(sub, a);
    m_rstart();
    wbyte(ab | 8'h01, a);
    chk("R6 read address ack", a, 1);
    for (int k = 0; k < n; k++) begin
      rbyte(v, k < n - 1);
      chk("R6 R5 R11 read data", v, model[sub[3:0]]);
    end
    hw(2);
    chk("R7 SDA released after controller nack", sda_oe, 0);
    rbit(b);
    chk("R7 nothing sent after nack", b, 1);
    m_stop();
    hw(4 * H);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic a;
    for (int i = 0; i < 16; i++) model[i] = 8'h00;
    m_scl = 1'b0; m_sda = 1'b0;
    addr_strap = 1'b0; busy = 1'b0; accept = 1'b1;
    rst_n = 1'b0;
    hw(5);
    chk("R10 reset scl_oe", scl_oe, 0);
    chk("R10 reset sda_oe", sda_oe, 0);
    chk("R10 reset wr_stb", wr_stb, 0);
    rst_n = 1'b1;
    hw(10);

    // R11 reset content, then plain and burst writes
    read_txn(8'hB8, 8'h05, 1);
    write_txn(8'hB8, 8'h03, 8'hA7, 1, 1'b1);
    write_txn(8'hB8, 8'h13, 8'h3C, 3, 1'b1);
    read_txn(8'hB8, 8'h03, 3);

    // R3 strap low, address with X=1
    write_txn(8'hBA, 8'h07, 8'h11, 1, 1'b0);
    // R2 strap high selects the other address
    addr_strap = 1'b1;
    write_txn(8'hBA, 8'h07, 8'h99, 2, 1'b1);
    write_txn(8'hB8, 8'h08, 8'h55, 1, 1'b0);
    addr_strap = 1'b0;
    read_txn(8'hB8, 8'h07, 1);

    // R1 stop in the middle of an address byte
    m_start(); wbit(1'b1); wbit(1'b0); wbit(1'b1); m_stop(); hw(4 * H);
    write_txn(8'hB8, 8'h0A, 8'h20, 1, 1'b1);

    // R1 repeated start in the middle of a data byte
    m_start(); wbyte(8'hB8, a); wbyte(8'h0B, a);
    wbit(1'b1); wbit(1'b1); wbit(1'b0); wbit(1'b1);
    m_rstart();
    wbyte(8'hB8, a);
    chk("R1 re-address after start", a, 1);
    wbyte(8'h0C, a);
    exp_q.push_back({8'h0C, 8'h77});
    wbyte(8'h77, a);
    m_stop(); hw(4 * H);
    read_txn(8'hB8, 8'h0B, 1);

    // R9 host refuses data
    m_start(); wbyte(8'hB8, a); wbyte(8'h0D, a);
    accept = 1'b0;
    wbyte(8'hE1, a);
    chk("R9 refused byte not acked", a, 0);
    accept = 1'b1;
    wbyte(8'hE2, a);
    chk("R9 later bytes ignored", a, 0);
    m_stop(); hw(4 * H);
    read_txn(8'hB8, 8'h0D, 1);

    // R8 wait state at the acknowledge bit
    m_start(); wbyte(8'hB8, a); wbyte(8'h0E, a);
    exp_q.push_back({8'h0E, 8'hC3});
    busy = 1'b1;
    fork
      wbyte(8'hC3, a);
      begin hw(460); busy = 1'b0; end
    join
    chk("R8 clock stretched while busy", last_wait >= 60, 1);
    chk("R8 ack after stall", a, 1);
    exp_q.push_back({8'h0E, 8'h3D});
    wbyte(8'h3D, a);
    chk("R8 no stretch when idle", last_wait <= 4, 1);
    m_stop(); hw(4 * H);
    read_txn(8'hB8, 8'h1E, 2);

    hw(10);
    chk("R4 all expected strobes seen", exp_q.size(), 0);
    chk("R10 target SDA steady during SCL high", glitch, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule